// File: doc/BRIEF.md
# Keyed-feed watchdog timer

This block guards a system against runaway software. A free-running prescaler advances on every timer tick. Through a selectable tap, it clocks an 8-bit down-counter. When software stops servicing the counter, the counter runs out and the block raises a one-cycle reset request. It also sets a sticky timeout flag that software can inspect after the restart.

Software services the counter by writing two fixed key bytes, in order, to two key registers on a small register bus. Nothing else may happen on the bus between the two writes. A correct pair restarts the counter from a software-chosen reload value and clears the prescaler. A correct first key followed by anything other than the correct second key is treated as a sign of corrupted control flow, and the block requests reset at once. The run bit and the tap select are written to a staging register. They take effect only on the next correct key pair, so a stray store cannot quietly disable the guard.

Top module: `wdog_keyed`

## Requirements
- R1: Control bits [2:0] select the counter clock divisor: code 0 gives 32 ticks, and each higher code doubles it, so code 7 gives 4096 ticks.
- R2: With ticks on every cycle, consecutive underflows are exactly divisor × (reload + 1) cycles apart. An underflow happens when the counter is 0 and a decrement arrives, and the counter then reloads.
- R3: Each underflow produces `rst_req` high for exactly one cycle, in the cycle after the underflow edge, and sets `timeout_flag` at the same edge.
- R4: Every reload clears the prescaler, so a reload value of 0 still gives one full divisor period per timeout.
- R5: A feed is a write of A5h to address 2 followed by a write of 5Ah to address 3, with no bus access in between. A feed loads the counter from the reload register (address 1) and clears the prescaler, and periodic feeds keep `rst_req` low.
- R6: After A5h has been written to address 2, any next bus access other than a write of 5Ah to address 3 pulses `rst_req` in the following cycle. A write of any other value to address 2 leaves the sequence disarmed, and a later write to address 3 then has no effect.
- R7: Writes to address 0 (bit 3 run, bits [2:0] tap) are staged. Reading address 0 returns the active setting, and the staged value becomes active only on a valid feed.
- R8: After reset, address 0 reads 0Fh (running, largest divisor), the reload register reads 00h, the counter reads 0, the flag is clear and `rst_req` is low.
- R9: Address 4 reads the timeout flag in bit 0. Writing 1 to bit 0 clears the flag, and an underflow in the same cycle wins.
- R10: While the active run bit is 0, the prescaler and counter hold and no underflow occurs.
- R11: Asserting `rst_n` clears the timeout flag, even when it coincides with an underflow.
- R12: Address 5 reads the current counter value. Addresses 6 and 7 read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Timer clock enable, advances the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| rst_req | output | 1 | One-cycle reset request |
| timeout_flag | output | 1 | Sticky underflow indication |

## Verification
The hardest case to reach from the ports is an external reset that lands on the very cycle of an underflow. The bench gets there by measuring the exact spacing between two earlier reset requests with the tick held high. It then counts forward by that spacing and drops `rst_n` just before the predicted edge. Broken key sequences form a second difficult class. A read placed between the keys is issued through the same scoreboarded read task, so its data is checked as well as the reset request it provokes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int TAP_W  = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_RELOAD = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_KEY1   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_KEY2   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_FLAG   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 3'd5;

  typedef struct packed {
    logic             run;
    logic [TAP_W-1:0] tap;
  } wd_ctrl_t;

  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_ARMED = 1'b1
  } key_state_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRESC_W    = 13,
  parameter int TAP_W      = 3,
  parameter int BASE_SHIFT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               run,
  input  logic               clear,
  input  logic [TAP_W-1:0]   tap_sel,
  output logic [PRESC_W-1:0] presc_q,
  output logic               dec_pulse
);
  localparam int NTAPS = 1 << TAP_W;

  logic [PRESC_W-1:0] presc_d;
  logic [NTAPS-1:0]   tap_full;

  // A tap fires when all bits below it are ones and another tick arrives.
  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    assign tap_full[g] = &presc_q[BASE_SHIFT+g-1:0];
  end

  assign dec_pulse = tick & run & tap_full[tap_sel];

  always_comb begin
    presc_d = presc_q;
    if (clear) begin
      presc_d = '0;
    end else if (tick && run) begin
      presc_d = presc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             uflow
);
  logic [CNT_W-1:0] cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  // A feed in the same cycle takes precedence over expiry.
  assign uflow   = dec & ~load & at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec) begin
      cnt_d = at_zero ? load_val : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
#(
  parameter int                ADDR_W  = 3,
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] KEY_A   = 8'hA5,
  parameter logic [DATA_W-1:0] KEY_B   = 8'h5A,
  parameter logic [ADDR_W-1:0] ADDR_A  = 3'd2,
  parameter logic [ADDR_W-1:0] ADDR_B  = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              feed_ok,
  output logic              key_fault
);
  key_state_t state_q, state_d;
  logic       first_ok, second_ok;

  assign first_ok  = wr && (addr == ADDR_A) && (wdata == KEY_A);
  assign second_ok = wr && !rd && (addr == ADDR_B) && (wdata == KEY_B);

  always_comb begin
    state_d   = state_q;
    feed_ok   = 1'b0;
    key_fault = 1'b0;
    unique case (state_q)
      KS_IDLE: begin
        if (first_ok) state_d = KS_ARMED;
      end
      KS_ARMED: begin
        if (wr || rd) begin
          state_d = KS_IDLE;
          if (second_ok) feed_ok   = 1'b1;
          else           key_fault = 1'b1;
        end
      end
      default: state_d = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int                PRESC_W    = 13,
  parameter int                BASE_SHIFT = 5,
  parameter int                CNT_W      = 8,
  parameter logic [DATA_W-1:0] KEY_A      = 8'hA5,
  parameter logic [DATA_W-1:0] KEY_B      = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic              timeout_flag
);
  localparam wd_ctrl_t CTRL_RST = '{run: 1'b1, tap: '1};

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  wd_ctrl_t         ctrl_act_q, ctrl_act_d, ctrl_pend_q, ctrl_pend_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             flag_q, flag_d;
  logic             rst_req_q, rst_req_d;

  logic               feed_ok, key_fault;
  logic               dec_pulse, uflow;
  logic [CNT_W-1:0]   cnt;
  logic [PRESC_W-1:0] presc;
  logic               wr_ctrl, wr_reload, wr_flag;

  wdog_keyseq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .KEY_A  (KEY_A),
    .KEY_B  (KEY_B),
    .ADDR_A (ADR_KEY1),
    .ADDR_B (ADR_KEY2)
  ) u_keys (
    .clk       (clk),
    .rst_n     (arst_n),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .feed_ok   (feed_ok),
    .key_fault (key_fault)
  );

  wdog_prescaler #(
    .PRESC_W    (PRESC_W),
    .TAP_W      (TAP_W),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_presc (
    .clk       (clk),
    .rst_n     (arst_n),
    .tick      (tick),
    .run       (ctrl_act_q.run),
    .clear     (feed_ok | uflow),
    .tap_sel   (ctrl_act_q.tap),
    .presc_q   (presc),
    .dec_pulse (dec_pulse)
  );

  wdog_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (arst_n),
    .dec      (dec_pulse),
    .load     (feed_ok),
    .load_val (reload_q),
    .cnt_q    (cnt),
    .uflow    (uflow)
  );

  assign wr_ctrl   = bus_wr && (bus_addr == ADR_CTRL);
  assign wr_reload = bus_wr && (bus_addr == ADR_RELOAD);
  assign wr_flag   = bus_wr && (bus_addr == ADR_FLAG) && bus_wdata[0];

  always_comb begin
    ctrl_pend_d = ctrl_pend_q;
    ctrl_act_d  = ctrl_act_q;
    reload_d    = reload_q;
    flag_d      = flag_q;
    if (wr_ctrl) begin
      ctrl_pend_d.run = bus_wdata[TAP_W];
      ctrl_pend_d.tap = bus_wdata[TAP_W-1:0];
    end
    if (feed_ok) ctrl_act_d = ctrl_pend_q;
    if (wr_reload) reload_d = bus_wdata[CNT_W-1:0];
    if (uflow)        flag_d = 1'b1;
    else if (wr_flag) flag_d = 1'b0;
    rst_req_d = uflow | key_fault;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ctrl_act_q  <= CTRL_RST;
      ctrl_pend_q <= CTRL_RST;
      reload_q    <= '0;
      flag_q      <= 1'b0;
      rst_req_q   <= 1'b0;
    end else begin
      ctrl_act_q  <= ctrl_act_d;
      ctrl_pend_q <= ctrl_pend_d;
      reload_q    <= reload_d;
      flag_q      <= flag_d;
      rst_req_q   <= rst_req_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTRL:   bus_rdata[TAP_W:0]   = {ctrl_act_q.run, ctrl_act_q.tap};
      ADR_RELOAD: bus_rdata[CNT_W-1:0] = reload_q;
      ADR_FLAG:   bus_rdata[0]         = flag_q;
      ADR_COUNT:  bus_rdata[CNT_W-1:0] = cnt;
      default:    bus_rdata            = '0;
    endcase
  end

  assign rst_req      = rst_req_q;
  assign timeout_flag = flag_q;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int CNT_W   = 8,
  parameter int PRESC_W = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               uflow,
  input logic               key_fault,
  input logic               feed_ok,
  input logic               rst_req,
  input logic               timeout_flag,
  input logic               run,
  input logic [CNT_W-1:0]   cnt,
  input logic [PRESC_W-1:0] presc,
  input logic [CNT_W-1:0]   reload
);
  AST_UFLOW_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> (rst_req && timeout_flag)); // R3

  AST_UFLOW_CLEARS_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> (presc == '0)); // R4

  AST_FEED_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> ((cnt == $past(reload)) && (presc == '0))); // R5

  AST_FAULT_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    key_fault |=> rst_req); // R6

  AST_FEED_NOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |-> !key_fault); // R6

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !feed_ok) |=> ($stable(cnt) && $stable(presc))); // R10

  AST_STOPPED_NO_UFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !uflow); // R10
endmodule

bind wdog_keyed wdog_keyed_chk #(
  .CNT_W   (CNT_W),
  .PRESC_W (PRESC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (arst_n),
  .uflow        (uflow),
  .key_fault    (key_fault),
  .feed_ok      (feed_ok),
  .rst_req      (rst_req),
  .timeout_flag (timeout_flag),
  .run          (ctrl_act_q.run),
  .cnt          (cnt),
  .presc        (presc),
  .reload       (reload_q)
);

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rst_req;
  logic       timeout_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_keyed dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .rst_req      (rst_req),
    .timeout_flag (timeout_flag)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_run = 0, n_fail = 0;
  int cyc = 0, n_pulse = 0, last_pulse = 0, prev_pulse = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // Monitor: pops expected read data, records reset request pulses.
  always @(negedge clk) begin
    if (bus_rd) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "scoreboard underrun", 0, 1);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(bus_rdata == it.exp, it.tag, int'(bus_rdata), int'(it.exp));
      end
    end
    if (rst_req) begin
      n_pulse++;
      prev_pulse = last_pulse;
      last_pulse = cyc;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    sb_q.push_back('{exp, tag});
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic feed();
    wr(3'd2, 8'hA5);
    wr(3'd3, 8'h5A);
  endtask

  task automatic wait_pulses(input int n);
    int tgt = n_pulse + n;
    while (n_pulse < tgt) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic interval(input int exp, input string tag);
    wait_pulses(2);
    chk(last_pulse - prev_pulse == exp, tag, last_pulse - prev_pulse, exp);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run incomplete actual=%0d expected<%0d cycles", WATCHDOG, WATCHDOG);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int base;
    do_reset();

    // R8: reset state
    chk(rst_req == 1'b0, "R8 rst_req low", int'(rst_req), 0);
    chk(timeout_flag == 1'b0, "R8 flag clear", int'(timeout_flag), 0);
    rd(3'd0, 8'h0F, "R8 ctrl reset");
    rd(3'd1, 8'h00, "R8 reload reset");
    rd(3'd5, 8'h00, "R8 counter reset");
    rd(3'd4, 8'h00, "R8 flag reg reset");

    // R1 R2 R8: defaults give 4096-tick timeout
    tick = 1'b1;
    interval(4096, "R2 default interval 4096");
    chk(timeout_flag == 1'b1, "R3 flag set on underflow", int'(timeout_flag), 1);
    rd(3'd4, 8'h01, "R9 flag reads 1");
    wr(3'd4, 8'h01);
    rd(3'd4, 8'h00, "R9 flag cleared by write");

    // R11: external reset on the underflow edge
    wait_pulses(1);
    chk(timeout_flag == 1'b1, "R3 flag set again", int'(timeout_flag), 1);
    base = last_pulse + 4096 - 1;
    while (cyc < base) begin @(posedge clk); #1; end
    base = n_pulse;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk(n_pulse == base, "R11 no request across reset", n_pulse, base);
    chk(timeout_flag == 1'b0, "R11 flag cleared by reset", int'(timeout_flag), 0);
    rd(3'd4, 8'h00, "R11 flag reg after reset");

    // R7 R12 R5: staged control, reload, feed
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h0F, "R7 staged ctrl not active");
    wr(3'd1, 8'h02);
    rd(3'd1, 8'h02, "R12 reload readback");
    feed();
    rd(3'd0, 8'h08, "R7 ctrl active after feed");
    rd(3'd5, 8'h02, "R5 counter loaded by feed");
    tick = 1'b1;
    interval(96, "R1 R2 tap0 reload2 interval 96");
    tick = 1'b0;

    // R4: reload 0 still gives a full divisor period
    wr(3'd0, 8'h09);
    wr(3'd1, 8'h00);
    feed();
    tick = 1'b1;
    interval(64, "R4 tap1 reload0 interval 64");
    tick = 1'b0;

    wr(3'd0, 8'h0B);
    wr(3'd1, 8'h01);
    feed();
    tick = 1'b1;
    interval(512, "R1 tap3 reload1 interval 512");
    tick = 1'b0;

    // R5: periodic feeds prevent reset
    wr(3'd0, 8'h08);
    wr(3'd1, 8'h02);
    feed();
    base = n_pulse;
    tick = 1'b1;
    for (int i = 0; i < 8; i++) begin
      repeat (40) @(posedge clk);
      feed();
    end
    tick = 1'b0;
    @(negedge clk); #1;
    chk(n_pulse == base, "R5 periodic feed keeps request low", n_pulse, base);

    // R6: broken sequences
    wr(3'd0, 8'h0C);
    base = n_pulse;
    wr(3'd2, 8'hA5);
    wr(3'd3, 8'h33);
    @(negedge clk); #1;
    chk(n_pulse == base + 1, "R6 wrong second key", n_pulse, base + 1);
    rd(3'd0, 8'h08, "R6 R7 ctrl unchanged after fault");
    base = n_pulse;
    wr(3'd2, 8'hA5);
    rd(3'd1, 8'h02, "R6 read between keys data");
    @(negedge clk); #1;
    chk(n_pulse == base + 1, "R6 read between keys", n_pulse, base + 1);
    base = n_pulse;
    wr(3'd2, 8'h11);
    wr(3'd3, 8'h5A);
    @(negedge clk); #1;
    chk(n_pulse == base, "R6 bad first key disarms", n_pulse, base);
    rd(3'd0, 8'h08, "R6 no feed after bad first key");
    feed();
    rd(3'd0, 8'h0C, "R7 staged ctrl applied");

    // R10: stopped watchdog holds
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h07);
    feed();
    rd(3'd0, 8'h00, "R10 run cleared");
    rd(3'd5, 8'h07, "R10 counter loaded");
    base = n_pulse;
    tick = 1'b1;
    repeat (6000) @(posedge clk);
    #1;
    rd(3'd5, 8'h07, "R10 counter held");
    tick = 1'b0;
    @(negedge clk); #1;
    chk(n_pulse == base, "R10 no underflow when stopped", n_pulse, base);

    // R12: unmapped addresses
    rd(3'd6, 8'h00, "R12 addr 6 reads zero");
    rd(3'd7, 8'h00, "R12 addr 7 reads zero");

    repeat (2) @(posedge clk);
    chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule